// File: doc/BRIEF.md
# Segment-Matched Slave Load Capture

This block sits on a slave filter device that shares a coefficient memory bus with a master. The master broadcasts a 4-bit segment number together with each byte it reads out of memory. Each slave compares that segment number with a device number fixed on its own pins. A slave takes a byte only when the two numbers are equal, so no external decoder or chip select is needed. Segment zero always belongs to the master, so a slave strapped to zero never accepts anything.

A separate control-select bit routes each accepted byte. While it is high, bytes go into a two-byte control word. The low byte arrives first, and the word changes only when the second byte has arrived. While control-select is low, bytes go to the coefficient store through a registered write port. Its address starts at zero for each load and advances by one on every accepted coefficient byte. A sticky loaded flag shows that the device has taken its coefficients and that the master has moved on to another segment.

Top module: `seg_slave_load`

## Requirements
- R1: A strobe whose segment number differs from the device number changes nothing: no coefficient write enable in the next cycle, and the control word, write address and loaded flag stay as they were.
- R2: A device number of 0 accepts no byte, whatever the segment number.
- R3: Control bytes are accepted while control-select is 1. The first byte becomes bits 7:0 and the second byte becomes bits 15:8. The control word changes only in the cycle after the second byte, so after a single byte it still shows its old value.
- R4: An accepted byte with control-select 0 gives a coefficient write enable of 1 for exactly one cycle, the cycle after the strobe, with that byte on the write data output.
- R5: The first coefficient write after reset, or after any accepted control byte, uses address 0. Each further accepted coefficient byte uses the previous address plus 1.
- R6: The loaded flag goes to 1 in the cycle after one in which the segment number differs from the device number, provided at least one coefficient byte was accepted since the last control byte. Without such a coefficient byte it stays 0.
- R7: An accepted control byte clears the loaded flag and starts a new load.
- R8: After reset the control word, write enable, write address, write data and loaded flag are all 0.
- R9: A byte accepted with control-select 1 never causes a coefficient write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_addr | input | 4 | Segment number broadcast by the master |
| dev_id | input | 4 | Device number fixed on the slave's pins |
| ctl_sel | input | 1 | 1 = byte goes to the control word, 0 = byte is a coefficient |
| wr_stb | input | 1 | Byte strobe, one cycle per byte |
| data_in | input | 8 | Broadcast data byte |
| ctl_word | output | 16 | Captured control word |
| coef_addr | output | 10 | Coefficient write address |
| coef_data | output | 8 | Coefficient write data |
| coef_we | output | 1 | Coefficient write enable |
| loaded | output | 1 | Load finished for this device |

## Verification
The assertions take for granted that the device number stays fixed while a load is in progress. They also take for granted that a strobe lasts exactly one cycle per byte. The address-step property further assumes that a coefficient write in two consecutive cycles means two consecutive strobes with no control byte between them. The stimulus keeps to these assumptions: it changes the device number only between separate loads, and it drives every strobe as a single-cycle pulse set up on the falling clock edge.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
    // Where an incoming byte is routed
    typedef enum logic [1:0] {
        STEER_NONE = 2'd0,
        STEER_CTL  = 2'd1,
        STEER_COEF = 2'd2
    } steer_e;
endpackage

// File: rtl/seg_match.sv
module seg_match
    import seg_load_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0] seg_addr,
    input  logic [SEG_W-1:0] dev_id,
    input  logic             wr_stb,
    input  logic             ctl_sel,
    output steer_e           steer,
    output logic             in_seg
);
    localparam logic [SEG_W-1:0] MASTER_SEG = '0;

    logic id_valid;

    always_comb begin
        id_valid = (dev_id != MASTER_SEG);
        in_seg   = (seg_addr == dev_id);
        steer    = STEER_NONE;
        if (wr_stb && in_seg && id_valid) begin
            steer = ctl_sel ? STEER_CTL : STEER_COEF;
        end
    end
endmodule

// File: rtl/ctl_capture.sv
module ctl_capture
    import seg_load_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  steer_e              steer,
    input  logic [DATA_W-1:0]   data_in,
    output logic [2*DATA_W-1:0] ctl_word
);
    localparam int CTL_W = 2 * DATA_W;

    typedef struct packed {
        logic              phase;
        logic [DATA_W-1:0] low;
        logic [CTL_W-1:0]  word;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (steer == STEER_CTL) begin
            if (!st_q.phase) begin
                st_d.low   = data_in;
                st_d.phase = 1'b1;
            end else begin
                st_d.word  = {data_in, st_q.low};
                st_d.phase = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_word = st_q.word;

    AST_CTL_PAIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.word) |-> ($past(st_q.phase) && !st_q.phase)); // R3
endmodule

// File: rtl/coef_writer.sv
module coef_writer
    import seg_load_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  steer_e            steer,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] coef_addr,
    output logic [DATA_W-1:0] coef_data,
    output logic              coef_we
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } coef_st_t;

    coef_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        unique case (steer)
            STEER_CTL:  st_d.ptr = '0;
            STEER_COEF: begin
                st_d.we   = 1'b1;
                st_d.addr = st_q.ptr;
                st_d.data = data_in;
                st_d.ptr  = st_q.ptr + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coef_addr = st_q.addr;
    assign coef_data = st_q.data;
    assign coef_we   = st_q.we;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.we && $past(st_q.we)) |-> (st_q.addr == $past(st_q.addr) + 1'b1)); // R5
    AST_CTL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (steer == STEER_CTL) |=> !st_q.we); // R9
endmodule

// File: rtl/load_tracker.sv
module load_tracker
    import seg_load_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  steer_e steer,
    input  logic   in_seg,
    output logic   loaded
);
    typedef struct packed {
        logic got;
        logic done;
    } load_st_t;

    load_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (steer == STEER_CTL) begin
            st_d = '0;
        end else begin
            if (steer == STEER_COEF) st_d.got = 1'b1;
            if (st_q.got && !in_seg) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign loaded = st_q.done;

    AST_LOADED_AFTER_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> !$past(in_seg)); // R6
    AST_CTL_CLEARS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (steer == STEER_CTL) |=> !st_q.done); // R7
endmodule

// File: rtl/seg_slave_load.sv
module seg_slave_load
    import seg_load_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEG_W-1:0]    seg_addr,
    input  logic [SEG_W-1:0]    dev_id,
    input  logic                ctl_sel,
    input  logic                wr_stb,
    input  logic [DATA_W-1:0]   data_in,
    output logic [2*DATA_W-1:0] ctl_word,
    output logic [ADDR_W-1:0]   coef_addr,
    output logic [DATA_W-1:0]   coef_data,
    output logic                coef_we,
    output logic                loaded
);
    steer_e steer;
    logic   in_seg;

    seg_match #(.SEG_W(SEG_W)) match_i (
        .seg_addr(seg_addr), .dev_id(dev_id), .wr_stb(wr_stb),
        .ctl_sel(ctl_sel), .steer(steer), .in_seg(in_seg)
    );

    ctl_capture #(.DATA_W(DATA_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .steer(steer), .data_in(data_in),
        .ctl_word(ctl_word)
    );

    coef_writer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) coef_i (
        .clk(clk), .rst_n(rst_n), .steer(steer), .data_in(data_in),
        .coef_addr(coef_addr), .coef_data(coef_data), .coef_we(coef_we)
    );

    load_tracker load_i (
        .clk(clk), .rst_n(rst_n), .steer(steer), .in_seg(in_seg),
        .loaded(loaded)
    );

    AST_FOREIGN_SEG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && seg_addr != dev_id) |=> (!coef_we && $stable(ctl_word) && $stable(coef_addr))); // R1
    AST_ZERO_ID_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && dev_id == '0) |=> (!coef_we && $stable(ctl_word))); // R2
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ctl_sel && seg_addr == dev_id && dev_id != '0) |=> coef_we); // R4
endmodule

// File: tb/seg_slave_load_tb_top.sv
`timescale 1ns/100ps
module seg_slave_load_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  seg_addr = '0;
    logic [3:0]  dev_id = 4'd5;
    logic        ctl_sel = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  data_in = '0;
    logic [15:0] ctl_word;
    logic [9:0]  coef_addr;
    logic [7:0]  coef_data;
    logic        coef_we;
    logic        loaded;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_slave_load dut_i (
        .clk(clk), .rst_n(rst_n), .seg_addr(seg_addr), .dev_id(dev_id),
        .ctl_sel(ctl_sel), .wr_stb(wr_stb), .data_in(data_in),
        .ctl_word(ctl_word), .coef_addr(coef_addr), .coef_data(coef_data),
        .coef_we(coef_we), .loaded(loaded)
    );

    typedef struct packed {
        logic [3:0]  seg;
        logic        ctl;
        logic        stb;
        logic [7:0]  d;
        logic        we;
        logic [9:0]  addr;
        logic [7:0]  wd;
        logic [15:0] cw;
        logic        ld;
    } vec_t;

    // device number 5 throughout the table
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd5, 1'b1, 1'b1, 8'h34, 1'b0, 10'd0, 8'h00, 16'h0000, 1'b0}, // R3 first byte, word unchanged
        '{4'd5, 1'b1, 1'b1, 8'h12, 1'b0, 10'd0, 8'h00, 16'h1234, 1'b0}, // R3 second byte
        '{4'd3, 1'b0, 1'b1, 8'hAA, 1'b0, 10'd0, 8'h00, 16'h1234, 1'b0}, // R1 foreign segment
        '{4'd5, 1'b0, 1'b1, 8'h11, 1'b1, 10'd0, 8'h11, 16'h1234, 1'b0}, // R4 R5
        '{4'd5, 1'b0, 1'b1, 8'h22, 1'b1, 10'd1, 8'h22, 16'h1234, 1'b0}, // R5
        '{4'd5, 1'b0, 1'b0, 8'h33, 1'b0, 10'd0, 8'h00, 16'h1234, 1'b0}, // R4 no strobe
        '{4'd5, 1'b0, 1'b1, 8'h44, 1'b1, 10'd2, 8'h44, 16'h1234, 1'b0}, // R5
        '{4'd6, 1'b0, 1'b0, 8'h00, 1'b0, 10'd0, 8'h00, 16'h1234, 1'b1}, // R6
        '{4'd6, 1'b0, 1'b1, 8'h99, 1'b0, 10'd0, 8'h00, 16'h1234, 1'b1}, // R1
        '{4'd5, 1'b1, 1'b1, 8'hCD, 1'b0, 10'd0, 8'h00, 16'h1234, 1'b0}, // R7 R9
        '{4'd5, 1'b1, 1'b1, 8'hAB, 1'b0, 10'd0, 8'h00, 16'hABCD, 1'b0}, // R3
        '{4'd5, 1'b0, 1'b1, 8'h55, 1'b1, 10'd0, 8'h55, 16'hABCD, 1'b0}  // R5 restart
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on falling edge, sample just after the next rising edge
    task automatic drive(input logic [3:0] s, input logic c, input logic st, input logic [7:0] d);
        @(negedge clk);
        seg_addr = s; ctl_sel = c; wr_stb = st; data_in = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 ctl_word", ctl_word, 16'h0);
        check("R8 coef_we", {15'b0, coef_we}, 16'h0);
        check("R8 coef_addr", {6'b0, coef_addr}, 16'h0);
        check("R8 coef_data", {8'b0, coef_data}, 16'h0);
        check("R8 loaded", {15'b0, loaded}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].seg, VEC[i].ctl, VEC[i].stb, VEC[i].d);
            check("R4 R9 coef_we", {15'b0, coef_we}, {15'b0, VEC[i].we});
            if (VEC[i].we) begin
                check("R5 coef_addr", {6'b0, coef_addr}, {6'b0, VEC[i].addr});
                check("R4 coef_data", {8'b0, coef_data}, {8'b0, VEC[i].wd});
            end
            check("R3 ctl_word", ctl_word, VEC[i].cw);
            check("R6 R7 loaded", {15'b0, loaded}, {15'b0, VEC[i].ld});
        end

        // R2: device number zero, segment zero, every kind of byte
        drive(4'd5, 1'b0, 1'b0, 8'h00);
        dev_id = 4'd0;
        drive(4'd0, 1'b0, 1'b1, 8'h77);
        check("R2 coef_we", {15'b0, coef_we}, 16'h0);
        drive(4'd0, 1'b1, 1'b1, 8'h01);
        drive(4'd0, 1'b1, 1'b1, 8'h02);
        check("R2 ctl_word", ctl_word, 16'hABCD);
        drive(4'd0, 1'b0, 1'b0, 8'h00);
        check("R2 coef_we idle", {15'b0, coef_we}, 16'h0);

        // R6: leaving the segment without any coefficient keeps loaded low
        dev_id = 4'd9;
        drive(4'd9, 1'b1, 1'b1, 8'h0F);
        drive(4'd9, 1'b1, 1'b1, 8'hF0);
        check("R3 ctl_word id9", ctl_word, 16'hF00F);
        drive(4'd2, 1'b0, 1'b0, 8'h00);
        drive(4'd2, 1'b0, 1'b0, 8'h00);
        check("R6 no coef loaded", {15'b0, loaded}, 16'h0);
        // R5: first coefficient after control bytes lands at address 0
        drive(4'd9, 1'b0, 1'b1, 8'h66);
        check("R5 addr after ctl", {6'b0, coef_addr}, 16'h0);
        check("R4 data id9", {8'b0, coef_data}, 16'h0066);
        drive(4'd9, 1'b0, 1'b0, 8'h00);
        check("R4 single cycle we", {15'b0, coef_we}, 16'h0);
        check("R6 still in segment", {15'b0, loaded}, 16'h0);
        drive(4'd1, 1'b0, 1'b0, 8'h00);
        check("R6 loaded rises", {15'b0, loaded}, 16'h1);
        // R1: foreign strobes leave the flag and address alone
        drive(4'd1, 1'b1, 1'b1, 8'hEE);
        check("R1 loaded kept", {15'b0, loaded}, 16'h1);
        check("R1 ctl kept", ctl_word, 16'hF00F);
        check("R1 addr kept", {6'b0, coef_addr}, 16'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule